// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt sources, 96 by default, and drives a single processor interrupt line. Each source has a pending bit, an enable bit and a mask bit. These bits are grouped into 32-bit banks. Source n lives in bank n/32 at bit n%32. Software reaches every bank through a simple single-cycle register bus. Writes take effect on the clock edge. Reads are combinational, so the data is valid in the same cycle as the address.

A vector register reports the lowest-numbered source that is both pending and enabled. It holds that source number shifted left by two, and a value of zero means nothing is pending. A handler therefore keeps reading the vector and servicing the source it names until the register reads zero. It acknowledges each source by writing a one to that source's pending bit. A source that is still asserted latches again on the following clock edge.

Two small registers are plain storage: a one-bit protection control and a two-bit external trigger-type field. A read-only fast-interrupt pending view mirrors the pending banks.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While source n is high at a clock edge, bit n%32 of pending bank n/32 (read address 0x10 + 4*bank) becomes 1. This happens whatever that source's enable and mask bits are.
- R2: A write to a pending bank clears every bit written as 1 at that edge, and leaves every bit written as 0 unchanged. Writing 0xFFFFFFFF clears the whole bank.
- R3: A clear takes priority at its own edge. If the source is still high, its pending bit reads 1 again after the next edge.
- R4: Enable banks (0x40 + 4*bank) read back what was written. A source whose enable bit is 0 never appears in the vector or on irq_o, but it still sets its pending bit.
- R5: A read of address 0x00 returns, in bits [8:2], the lowest-numbered source n ≥ 1 that is both pending and enabled. All other bits read 0. The whole word is 0 when no such source exists, and source 0 is never reported.
- R6: irq_o is 1 exactly when some source n ≥ 1 is pending, enabled and has mask bit 0. A mask bit of 1 removes the source from irq_o only; the vector still reports it.
- R7: Mask banks (0x50 + 4*bank) read back what was written.
- R8: Address 0x08 stores bit 0 and address 0x0C stores bits [1:0]. Both read back their stored value with all other bits reading 0.
- R9: Addresses 0x20 + 4*bank read the same value as the matching pending bank. Writes to them have no effect.
- R10: After reset, every pending, enable and mask bit, the two control registers, the vector and irq_o are all 0.
- R11: Read data follows the address in the same cycle. Unmapped addresses such as 0x04 read 0, and writes to the vector address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Level interrupt sources |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Processor interrupt request |

## Verification
The bench drives every source on its own, one at a time. This single-hot sweep shows the bank and bit placement, the vector encoding, the reserved behaviour of source 0, the write-one-to-clear rule and the re-latch of a held source. It then drives every unordered pair of sources. The pair sweep tells a lowest-first priority apart from highest-first or last-written selection. Targeted patterns with selected enable and mask bits separate the vector path from the interrupt-line path. A final all-sources-high pattern confirms that a full-bank clear works.

// File: rtl/lic_pkg.sv
package lic_pkg;
   localparam int BANK_W   = 32;
   localparam int NMI_W    = 2;
   localparam int OFS_VEC  = 'h00;
   localparam int OFS_PROT = 'h08;
   localparam int OFS_NMI  = 'h0C;
   localparam int OFS_PEND = 'h10;
   localparam int OFS_FIQ  = 'h20;
   localparam int OFS_EN   = 'h40;
   localparam int OFS_MASK = 'h50;
   localparam int MAX_BANK = 4;

   typedef logic [BANK_W-1:0] bank_word_t;
endpackage

// File: rtl/lic_bank.sv
module lic_bank
   import lic_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  bank_word_t src_i,
   input  bank_word_t clr_i,
   input  logic       wr_en_i,
   input  logic       wr_mask_i,
   input  bank_word_t wdata_i,
   output bank_word_t pend_o,
   output bank_word_t en_o,
   output bank_word_t mask_o
);
   bank_word_t pend_q, en_q, mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         en_q   <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= (pend_q | src_i) & ~clr_i;
         if (wr_en_i)   en_q   <= wdata_i;
         if (wr_mask_i) mask_q <= wdata_i;
      end
   end

   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/lic_prio.sv
module lic_prio
   import lic_pkg::*;
#(
   parameter int N         = 96,
   parameter int PRIO_ARCH = 1,
   localparam int IDX_W    = $clog2(N),
   localparam int NB       = N / BANK_W
) (
   input  logic [N-1:0]     req_i,
   output logic [IDX_W-1:0] idx_o
);
   generate
      if (PRIO_ARCH == 0) begin : g_linear
         always_comb begin
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) idx_o = IDX_W'(i);
            end
         end
      end else begin : g_banked
         logic [NB-1:0]        any_b;
         logic [4:0]           low_b [NB];
         for (genvar b = 0; b < NB; b++) begin : g_bank
            always_comb begin
               low_b[b] = '0;
               for (int i = BANK_W - 1; i >= 0; i--) begin
                  if (req_i[b*BANK_W+i]) low_b[b] = 5'(i);
               end
            end
            assign any_b[b] = |req_i[b*BANK_W +: BANK_W];
         end
         always_comb begin
            idx_o = '0;
            for (int b = NB - 1; b >= 0; b--) begin
               if (any_b[b]) idx_o = IDX_W'(b * BANK_W) + IDX_W'(low_b[b]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lic_regif.sv
module lic_regif
   import lic_pkg::*;
#(
   parameter int NB       = 3,
   parameter int ADDR_W   = 8,
   parameter int IDX_W    = 7,
   localparam int NSRC    = NB * BANK_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  bank_word_t        wdata_i,
   input  logic [NSRC-1:0]   pend_i,
   input  logic [NSRC-1:0]   en_i,
   input  logic [NSRC-1:0]   mask_i,
   input  logic [IDX_W-1:0]  vec_i,
   input  logic              prot_i,
   input  logic [NMI_W-1:0]  nmi_i,
   output logic [NB-1:0]     wr_pend_o,
   output logic [NB-1:0]     wr_en_o,
   output logic [NB-1:0]     wr_mask_o,
   output logic              wr_prot_o,
   output logic              wr_nmi_o,
   output bank_word_t        rdata_o
);
   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   generate
      for (genvar b = 0; b < NB; b++) begin : g_wr
         assign wr_pend_o[b] = we_i && hit(addr_i, OFS_PEND + 4*b);
         assign wr_en_o[b]   = we_i && hit(addr_i, OFS_EN + 4*b);
         assign wr_mask_o[b] = we_i && hit(addr_i, OFS_MASK + 4*b);
      end
   endgenerate

   assign wr_prot_o = we_i && hit(addr_i, OFS_PROT);
   assign wr_nmi_o  = we_i && hit(addr_i, OFS_NMI);

   always_comb begin
      rdata_o = '0;
      if (hit(addr_i, OFS_VEC))  rdata_o = BANK_W'({vec_i, 2'b00});
      if (hit(addr_i, OFS_PROT)) rdata_o = BANK_W'(prot_i);
      if (hit(addr_i, OFS_NMI))  rdata_o = BANK_W'(nmi_i);
      for (int b = 0; b < NB; b++) begin
         if (hit(addr_i, OFS_PEND + 4*b)) rdata_o = pend_i[b*BANK_W +: BANK_W];
         if (hit(addr_i, OFS_FIQ + 4*b))  rdata_o = pend_i[b*BANK_W +: BANK_W];
         if (hit(addr_i, OFS_EN + 4*b))   rdata_o = en_i[b*BANK_W +: BANK_W];
         if (hit(addr_i, OFS_MASK + 4*b)) rdata_o = mask_i[b*BANK_W +: BANK_W];
      end
   end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lic_pkg::*;
#(
   parameter int NUM_SRC   = 96,
   parameter int ADDR_W    = 8,
   parameter int PRIO_ARCH = 1,
   localparam int NB       = NUM_SRC / BANK_W,
   localparam int IDX_W    = $clog2(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] irq_src_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   output logic               irq_o
);
   generate
      if (NUM_SRC % BANK_W != 0 || NB < 1 || NB > MAX_BANK) begin : g_bad_src
         $error("NUM_SRC must be 32, 64, 96 or 128");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must be at least 7");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend_all, en_all, mask_all, clr_all, req_all;
   logic [NB-1:0]      wr_pend, wr_en, wr_mask;
   logic               wr_prot, wr_nmi;
   logic               prot_q;
   logic [NMI_W-1:0]   nmi_q;
   logic [IDX_W-1:0]   vec_idx;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         assign clr_all[b*BANK_W +: BANK_W] = wr_pend[b] ? bus_wdata_i : '0;
         lic_bank u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .src_i     (irq_src_i[b*BANK_W +: BANK_W]),
            .clr_i     (clr_all[b*BANK_W +: BANK_W]),
            .wr_en_i   (wr_en[b]),
            .wr_mask_i (wr_mask[b]),
            .wdata_i   (bus_wdata_i),
            .pend_o    (pend_all[b*BANK_W +: BANK_W]),
            .en_o      (en_all[b*BANK_W +: BANK_W]),
            .mask_o    (mask_all[b*BANK_W +: BANK_W])
         );
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prot_q <= 1'b0;
         nmi_q  <= '0;
      end else begin
         if (wr_prot) prot_q <= bus_wdata_i[0];
         if (wr_nmi)  nmi_q  <= bus_wdata_i[NMI_W-1:0];
      end
   end

   // source 0 is reserved: a zero vector means idle
   assign req_all = pend_all & en_all & {{(NUM_SRC-1){1'b1}}, 1'b0};

   lic_prio #(.N(NUM_SRC), .PRIO_ARCH(PRIO_ARCH)) u_prio (
      .req_i (req_all),
      .idx_o (vec_idx)
   );

   lic_regif #(.NB(NB), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regif (
      .addr_i    (bus_addr_i),
      .we_i      (bus_we_i),
      .wdata_i   (bus_wdata_i),
      .pend_i    (pend_all),
      .en_i      (en_all),
      .mask_i    (mask_all),
      .vec_i     (vec_idx),
      .prot_i    (prot_q),
      .nmi_i     (nmi_q),
      .wr_pend_o (wr_pend),
      .wr_en_o   (wr_en),
      .wr_mask_o (wr_mask),
      .wr_prot_o (wr_prot),
      .wr_nmi_o  (wr_nmi),
      .rdata_o   (bus_rdata_o)
   );

   assign irq_o = |(req_all & ~mask_all);
endmodule

// File: rtl/lic_chk.sv
module lic_chk #(
   parameter int NUM_SRC = 96,
   parameter int ADDR_W  = 8,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] irq_src_i,
   input logic               bus_we_i,
   input logic [ADDR_W-1:0]  bus_addr_i,
   input logic [31:0]        bus_wdata_i,
   input logic [31:0]        bus_rdata_o,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] pend_all,
   input logic [NUM_SRC-1:0] en_all,
   input logic [NUM_SRC-1:0] clr_all,
   input logic [IDX_W-1:0]   vec_idx
);
   // R5
   vec_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_idx != '0) |-> (pend_all[vec_idx] && en_all[vec_idx]));

   // R6
   irq_has_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (vec_idx != '0));

   // R2
   w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|clr_all) |=> ((pend_all & $past(clr_all)) == '0));

   // R3
   relatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(irq_src_i & ~clr_all)) |=>
      ((pend_all & $past(irq_src_i & ~clr_all)) == $past(irq_src_i & ~clr_all)));

   // R4
   en_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == ADDR_W'('h40)) |=> (en_all[31:0] == $past(bus_wdata_i)));

   // R5
   vec_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == '0) |-> (bus_rdata_o == 32'({vec_idx, 2'b00})));
endmodule

bind lvl_irq_ctrl lic_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .irq_src_i   (irq_src_i),
   .bus_we_i    (bus_we_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .pend_all    (pend_all),
   .en_all      (en_all),
   .clr_all     (clr_all),
   .vec_idx     (vec_idx)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
   localparam int N = 96;

   logic         clk = 1'b0;
   logic         rst_ni = 1'b0;
   logic [N-1:0] src = '0;
   logic         we = 1'b0;
   logic [7:0]   addr = '0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic         irq;
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   lvl_irq_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .irq_src_i(src), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      step();
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      src = '0;
      for (int b = 0; b < 3; b++) wr(8'(8'h10 + 4*b), 32'hFFFF_FFFF);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      step(); step();
      rst_ni = 1'b1;
      step();

      // R10 reset state
      for (int b = 0; b < 3; b++) begin
         rd(8'(8'h10 + 4*b), d); chk("R10 pend", d, 0);
         rd(8'(8'h40 + 4*b), d); chk("R10 en", d, 0);
         rd(8'(8'h50 + 4*b), d); chk("R10 mask", d, 0);
      end
      rd(8'h00, d); chk("R10 vec", d, 0);
      rd(8'h08, d); chk("R10 prot", d, 0);
      rd(8'h0C, d); chk("R10 nmi", d, 0);
      chk("R10 irq", 32'(irq), 0);

      // R8 control storage
      wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R8 prot", d, 1);
      wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R8 nmi", d, 3);
      wr(8'h0C, 32'h0000_0002); rd(8'h0C, d); chk("R8 nmi", d, 2);
      wr(8'h08, 32'h0); rd(8'h08, d); chk("R8 prot", d, 0);

      // R11 unmapped and vector write
      rd(8'h04, d); chk("R11 unmapped", d, 0);
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R11 vec write", d, 0);

      // R4 enable all
      for (int b = 0; b < 3; b++) begin
         wr(8'(8'h40 + 4*b), 32'hFFFF_FFFF);
         rd(8'(8'h40 + 4*b), d); chk("R4 en readback", d, 32'hFFFF_FFFF);
      end

      // single-source sweep
      for (int n = 0; n < N; n++) begin
         logic [7:0]  pa;
         logic [31:0] bit_v;
         pa = 8'(8'h10 + 4*(n/32));
         bit_v = 32'(1) << (n % 32);
         src = '0; src[n] = 1'b1;
         step();
         rd(pa, d); chk("R1 pend", d, bit_v);
         rd(8'(8'h20 + 4*(n/32)), d); chk("R9 fiq", d, bit_v);
         rd(8'h00, d); chk("R5 vec", d, (n == 0) ? 32'd0 : 32'(n) << 2);
         chk("R6 irq", 32'(irq), (n == 0) ? 32'd0 : 32'd1);
         wr(pa, 32'h0); rd(pa, d); chk("R2 zero write", d, bit_v);
         wr(pa, bit_v); rd(pa, d); chk("R2 w1c", d, 0);
         step(); rd(pa, d); chk("R3 relatch", d, bit_v);
         src = '0;
         wr(pa, bit_v); rd(pa, d); chk("R2 clear", d, 0);
      end

      // R9 fiq mirror ignores writes
      src[33] = 1'b1; step(); src = '0;
      wr(8'h24, 32'hFFFF_FFFF); rd(8'h14, d); chk("R9 fiq write", d, 32'h2);
      clear_all();

      // pair sweep: lowest number wins
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            int lo;
            lo = (i == 0) ? j : i;
            src = '0; src[i] = 1'b1; src[j] = 1'b1;
            step();
            rd(8'h00, d); chk("R5 pair", d, 32'(lo) << 2);
            clear_all();
         end
      end

      // R4 disable source 40
      wr(8'h44, ~(32'(1) << 8));
      src = '0; src[40] = 1'b1; src[70] = 1'b1;
      step();
      rd(8'h00, d); chk("R4 disabled skip", d, 32'(70) << 2);
      rd(8'h14, d); chk("R4 pend kept", d, 32'(1) << 8);
      chk("R6 irq on", 32'(irq), 1);
      // R7 mask 70
      wr(8'h58, 32'(1) << 6);
      rd(8'h58, d); chk("R7 mask readback", d, 32'(1) << 6);
      chk("R6 masked irq", 32'(irq), 0);
      rd(8'h00, d); chk("R6 masked vec", d, 32'(70) << 2);
      wr(8'h48, 32'h0);
      rd(8'h00, d); chk("R4 all off vec", d, 0);
      chk("R4 all off irq", 32'(irq), 0);

      // R2 full-bank clear
      src = '1; step(); src = '0;
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, d); chk("R2 full clear", d, 0);
      rd(8'h14, d); chk("R2 other bank", d, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule